// File: doc/BRIEF.md
# Synchronization Reference Selector

This block chooses which incoming line-derived clock the exchange clock follows. Every candidate input arrives with a good/bad qualifier from its line interface. The selector watches all of them all the time, including the ones it is not using. An input is trusted only after its qualifier has stayed high over a run of check ticks. Of the trusted inputs, the one with the highest rank is used, and input 0 has the highest rank.

The block has two modes. In slave mode it tracks the chosen input. In free-run (plesiochronous) mode no input is used. When no trusted input is left, the selector drops into free-run on its own. It leaves free-run under a configurable policy. With automatic revert it leaves as soon as a trusted input exists. With manual revert it waits for a one-cycle operator strobe. The automatic policy also lets a newly trusted input of higher rank take over from the current one.

Every change of mode or of the chosen index raises a one-cycle pulse, so the downstream phase-locked loop can re-acquire. The loop itself, the wander measurement and the oscillator are outside this block.

Top module: `sync_ref_selector`

## Requirements
- R1: After reset, mode_o is 0 (free-run), sel_idx_o is 0 and switch_pulse_o is 0.
- R2: An input becomes trusted only once its qualifier has been high at QUAL_TICKS consecutive cycles where tick_i is high (default 8). A single clock cycle with the qualifier low restarts that count from zero.
- R3: Whenever a selection is made, the lowest-numbered trusted input is chosen. A trusted input of lower rank (higher number) never displaces the current one.
- R4: In slave mode, if the selected input stops being trusted while another input is trusted, the selector moves to the best trusted input within two clock cycles. This happens under either revert policy.
- R5: In slave mode, if the selected input stops being trusted and no input is trusted, mode_o returns to 0. In free-run, sel_idx_o reads 0.
- R6: In free-run with auto_revert_i = 1, the clock edge that first sees a trusted input switches the block to slave mode (mode_o = 1) on that input.
- R7: With auto_revert_i = 0, free-run is left only on a clock edge where revert_cmd_i is high and a trusted input exists. The strobe has no effect when no input is trusted, and no effect in slave mode.
- R8: In slave mode with auto_revert_i = 1, a higher-rank input that becomes trusted takes over. With auto_revert_i = 0, the current input is kept while it stays trusted.
- R9: switch_pulse_o is high for exactly one cycle, the first cycle in which a new mode_o or sel_idx_o value is visible. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Check tick that advances qualification counts |
| qual_i | input | NUM_IN | Per-input good/bad qualifier, 1 = good |
| auto_revert_i | input | 1 | 1 = automatic revert and preemption, 0 = manual |
| revert_cmd_i | input | 1 | One-cycle operator strobe to leave free-run |
| sel_idx_o | output | IDX_W | Index of the followed input, 0 in free-run |
| mode_o | output | 1 | 0 = free-run, 1 = slave |
| switch_pulse_o | output | 1 | One-cycle pulse on any change of selection or mode |

## Verification
The bench goes after the qualification boundary. It applies one tick short of the threshold, then a one-cycle qualifier dropout in the middle of a run. A filter that does not restart its count would pick up the input too early. The bench also covers the rank cases. A higher-rank input must preempt under automatic policy and must not preempt under manual policy. A lower-rank input must never displace the current one. A design with an inverted priority encoder or an ungated preemption would switch when it should not.

The manual path is tested three ways: a strobe with no trusted input, a strobe in slave mode, and a missing strobe. Each one catches a selector that leaves or disturbs free-run on its own. Every switchover pulse is matched against a queue of expected changes. A missing pulse, an extra pulse or a wrong target is reported.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic {
        MODE_FREE  = 1'b0,
        MODE_SLAVE = 1'b1
    } clk_mode_e;

endpackage

// File: rtl/sref_qual_filter.sv
// Per-input persistence filter: trusted after TICKS consecutive good ticks.
module sref_qual_filter #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic qual_i,
    output logic good_o
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!qual_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != FULL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign good_o = (st_q.cnt == FULL);

endmodule

// File: rtl/sref_prio_pick.sv
// Lowest index among trusted inputs wins.
module sref_prio_pick #(
    parameter int NUM_IN = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_IN-1:0] good_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (good_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sref_mode_fsm.sv
module sref_mode_fsm
    import sref_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] good_i,
    input  logic              any_good_i,
    input  logic [IDX_W-1:0]  best_idx_i,
    input  logic              auto_revert_i,
    input  logic              revert_cmd_i,
    output logic [IDX_W-1:0]  sel_idx_o,
    output clk_mode_e         mode_o,
    output logic              switch_pulse_o
);
    typedef struct packed {
        clk_mode_e        mode;
        logic [IDX_W-1:0] sel;
        logic             pulse;
    } fsm_t;

    fsm_t st_d, st_q;
    logic cur_good;

    assign cur_good = good_i[st_q.sel];

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        unique case (st_q.mode)
            MODE_FREE: begin
                if (any_good_i && (auto_revert_i || revert_cmd_i)) begin
                    st_d.mode  = MODE_SLAVE;
                    st_d.sel   = best_idx_i;
                    st_d.pulse = 1'b1;
                end
            end
            MODE_SLAVE: begin
                if (!cur_good) begin
                    if (any_good_i) begin
                        st_d.sel = best_idx_i;
                    end else begin
                        st_d.mode = MODE_FREE;
                        st_d.sel  = '0;
                    end
                    st_d.pulse = 1'b1;
                end else if (auto_revert_i && (best_idx_i < st_q.sel)) begin
                    st_d.sel   = best_idx_i;
                    st_d.pulse = 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_FREE;
            st_q.sel   <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx_o      = st_q.sel;
    assign mode_o         = st_q.mode;
    assign switch_pulse_o = st_q.pulse;

endmodule

// File: rtl/sync_ref_selector.sv
module sync_ref_selector
    import sref_pkg::*;
#(
    parameter int NUM_IN     = 4,
    parameter int QUAL_TICKS = 8,
    localparam int IDX_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NUM_IN-1:0] qual_i,
    input  logic              auto_revert_i,
    input  logic              revert_cmd_i,
    output logic [IDX_W-1:0]  sel_idx_o,
    output logic              mode_o,
    output logic              switch_pulse_o
);
    logic [NUM_IN-1:0] good_vec;
    logic              any_good;
    logic [IDX_W-1:0]  best_idx;
    clk_mode_e         mode_s;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_filt
        sref_qual_filter #(.TICKS(QUAL_TICKS)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .qual_i (qual_i[g]),
            .good_o (good_vec[g])
        );
    end

    sref_prio_pick #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_pick (
        .good_i (good_vec),
        .any_o  (any_good),
        .idx_o  (best_idx)
    );

    sref_mode_fsm #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .good_i         (good_vec),
        .any_good_i     (any_good),
        .best_idx_i     (best_idx),
        .auto_revert_i  (auto_revert_i),
        .revert_cmd_i   (revert_cmd_i),
        .sel_idx_o      (sel_idx_o),
        .mode_o         (mode_s),
        .switch_pulse_o (switch_pulse_o)
    );

    assign mode_o = mode_s;

endmodule

// File: rtl/sync_ref_selector_chk.sv
module sync_ref_selector_chk #(
    parameter int NUM_IN = 4,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_revert_i,
    input logic              revert_cmd_i,
    input logic [NUM_IN-1:0] good_vec,
    input logic [IDX_W-1:0]  sel_idx_o,
    input logic              mode_o,
    input logic              switch_pulse_o
);
    // R1: reset leaves free-run with no pulse
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 1'b0 && sel_idx_o == '0 && !switch_pulse_o));

    // R9: any visible change carries the pulse
    a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o) || sel_idx_o != $past(sel_idx_o)) |-> switch_pulse_o);

    // R9: no pulse without a change
    a_r9_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse_o |-> (mode_o != $past(mode_o) || sel_idx_o != $past(sel_idx_o)));

    // R5: free-run reports index 0
    a_r5_free_index: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 1'b0) |-> (sel_idx_o == '0));

    // R7: manual policy without strobe holds free-run
    a_r7_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 1'b0 && !auto_revert_i && !revert_cmd_i) |=> (mode_o == 1'b0));

    // R2: nothing trusted, nothing selected
    a_r2_no_early_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 1'b0 && good_vec == '0) |=> (mode_o == 1'b0));

    // R8: manual policy keeps a trusted current input
    a_r8_manual_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 1'b1 && !auto_revert_i && good_vec[sel_idx_o]) |=> $stable(sel_idx_o));

endmodule

bind sync_ref_selector sync_ref_selector_chk #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .auto_revert_i  (auto_revert_i),
    .revert_cmd_i   (revert_cmd_i),
    .good_vec       (good_vec),
    .sel_idx_o      (sel_idx_o),
    .mode_o         (mode_o),
    .switch_pulse_o (switch_pulse_o)
);

// File: tb/sync_ref_selector_tb.sv
module sync_ref_selector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IN     = 4;
    localparam int QT         = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic [NUM_IN-1:0] qual_i = '0;
    logic              auto_revert_i = 1'b1;
    logic              revert_cmd_i = 1'b0;
    logic [1:0]        sel_idx_o;
    logic              mode_o;
    logic              switch_pulse_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic       mode;
        logic [1:0] sel;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_ref_selector #(.NUM_IN(NUM_IN), .QUAL_TICKS(QT)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .qual_i         (qual_i),
        .auto_revert_i  (auto_revert_i),
        .revert_cmd_i   (revert_cmd_i),
        .sel_idx_o      (sel_idx_o),
        .mode_o         (mode_o),
        .switch_pulse_o (switch_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_switch(input logic m, input logic [1:0] s, input string req);
        exp_t e;
        e.mode = m; e.sel = s; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: every pulse must match the next expected switchover
    always @(negedge clk) begin
        if (rst_n && switch_pulse_o) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R9: unexpected pulse, actual mode %0d sel %0d expected no pulse",
                         mode_o, sel_idx_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " mode"}, int'(mode_o), int'(e.mode));
                check({e.req, " sel"},  int'(sel_idx_o), int'(e.sel));
            end
        end
    end

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) revert_cmd_i = 1'b1;
        @(negedge clk) revert_cmd_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode", int'(mode_o), 0);
        check("R1 sel", int'(sel_idx_o), 0);
        check("R1 pulse", int'(switch_pulse_o), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2: one tick short stays in free-run
        qual_i[2] = 1'b1;
        ticks(QT - 1);
        settle();
        check("R2 short run mode", int'(mode_o), 0);
        // R6: threshold reached -> automatic entry to slave
        expect_switch(1'b1, 2'd2, "R6");
        ticks(1);
        settle();
        check("R6 mode", int'(mode_o), 1);
        check("R6 sel", int'(sel_idx_o), 2);

        // R8: higher-rank input takes over under auto policy
        qual_i[1] = 1'b1;
        expect_switch(1'b1, 2'd1, "R8 preempt");
        ticks(QT);
        settle();
        check("R8 preempt sel", int'(sel_idx_o), 1);

        // R3: lower-rank input becoming trusted changes nothing
        qual_i[3] = 1'b1;
        ticks(QT);
        settle();
        check("R3 lower rank sel", int'(sel_idx_o), 1);

        // R4: selected input lost, best remaining is 2
        expect_switch(1'b1, 2'd2, "R4 failover");
        @(negedge clk) qual_i[1] = 1'b0;
        settle();
        check("R4 failover sel", int'(sel_idx_o), 2);

        // R2: dropout mid-run restarts the count
        qual_i[0] = 1'b1;
        ticks(5);
        @(negedge clk) qual_i[0] = 1'b0;
        @(negedge clk) qual_i[0] = 1'b1;
        ticks(5);
        settle();
        check("R2 restart sel", int'(sel_idx_o), 2);
        expect_switch(1'b1, 2'd0, "R2 full run");
        ticks(QT - 5);
        settle();
        check("R2 full run sel", int'(sel_idx_o), 0);

        // R5: everything lost -> free-run, index 0
        @(negedge clk) auto_revert_i = 1'b0;
        expect_switch(1'b0, 2'd0, "R5 fallback");
        @(negedge clk) qual_i = '0;
        settle();
        check("R5 mode", int'(mode_o), 0);
        check("R5 sel", int'(sel_idx_o), 0);

        // R7: strobe with nothing trusted has no effect
        strobe();
        settle();
        check("R7 empty strobe mode", int'(mode_o), 0);

        // R7: manual policy waits for the strobe
        qual_i[3] = 1'b1;
        ticks(QT);
        repeat (10) @(negedge clk);
        check("R7 waits mode", int'(mode_o), 0);
        expect_switch(1'b1, 2'd3, "R7 strobe");
        strobe();
        settle();
        check("R7 strobe mode", int'(mode_o), 1);
        check("R7 strobe sel", int'(sel_idx_o), 3);

        // R8: manual policy keeps current input despite higher rank
        qual_i[0] = 1'b1;
        ticks(QT);
        settle();
        check("R8 manual keep sel", int'(sel_idx_o), 3);
        // R7: strobe in slave mode has no effect
        strobe();
        settle();
        check("R7 slave strobe sel", int'(sel_idx_o), 3);

        // R4: failover also under manual policy
        expect_switch(1'b1, 2'd0, "R4 manual failover");
        @(negedge clk) qual_i[3] = 1'b0;
        settle();
        check("R4 manual failover sel", int'(sel_idx_o), 0);

        // R5 again under manual policy
        expect_switch(1'b0, 2'd0, "R5 manual fallback");
        @(negedge clk) qual_i[0] = 1'b0;
        settle();
        check("R5 manual mode", int'(mode_o), 0);

        repeat (5) @(negedge clk);
        check("R9 all expected pulses seen", sb_q.size(), 0);
        finish_run();
    end

endmodule